// File: doc/BRIEF.md
# Coincidence-Merged Trigger Event Counter

This block counts physical events seen on sixteen trigger lines. The lines have already been sampled on a 1 ns grid and widened so that every 125 MHz clock brings one 8-sample word per line, which covers 8 ns of input time. For each line the block finds rising edges and suppresses any new edge for a short hold-off after an accepted one. The hold-off and the edge memory carry from one word into the next. Accepted edges from all lines are then merged slot by slot, so a pulse that hits several lines in the same 1 ns slot counts once.

The merged count of each clock cycle is added into a running total. A free-running gate of 625 cycles (5 µs) sets the measurement window. When the gate closes, the total for the whole window is latched on the output, a one-cycle flag marks the new value, and counting starts again from zero for the next window.

Top module: `coinc_event_counter`

## Requirements
- R1: A synchronous active-high reset clears the window position, the running sum, the per-line edge memory and hold-off state, and the output; while reset is high and in the cycle after it, `event_total` is 0 and `count_valid` is 0.
- R2: Bit 0 of each line's 8-bit field in `trig_words` (line c occupies bits 8c+7 down to 8c) is the earliest sample and bit 7 the latest; an edge is a 1 in a slot whose preceding sample on that line is 0, so a line held high counts once.
- R3: The preceding sample for bit 0 is bit 7 of the same line's previous word, so a level that stays high across a word boundary gives no new edge and a 0 in bit 7 followed by a 1 in bit 0 gives one.
- R4: After an edge accepted at slot t, edges on that line at slots t+1 to t+5 are ignored, and an edge at slot t+6 is accepted.
- R5: The hold-off of R4 counts in 1 ns slots across word boundaries.
- R6: Accepted edges on any number of lines in the same slot count as one event.
- R7: Accepted edges in different slots count as separate events, whether or not they are on the same line or word.
- R8: Hold-off is per line: an edge on another line during a line's hold-off is counted, and a blocked edge adds nothing to a slot.
- R9: `count_valid` is high for exactly one cycle every 625 cycles; the first pulse appears after the 625th clock edge with reset low.
- R10: On each `count_valid` pulse `event_total` equals the number of events of the 625 cycles of that window, and it holds that value until the next pulse.
- R11: With eight events in every cycle, the total reaches 5000 without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz processing clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_words | input | 128 | Sixteen 8-sample words, line c in bits 8c+7:8c, bit 0 earliest |
| event_total | output | 13 | Event count of the most recent completed window |
| count_valid | output | 1 | One-cycle flag that `event_total` was just updated |

## Verification
Directed words place edges at chosen slots. Isolated pulses and held-high levels separate edge detection from level counting. Patterns that straddle a word boundary show whether the last sample and the hold-off countdown really carry over. Same-slot pulses on many lines, set against pulses in neighbouring slots, tell coincidence merging apart from plain per-line summing, and an edge on one line during another line's hold-off shows that the blocking stays local to its line. A saturating pattern of one event in every slot checks the top of the range, and sparse random words over several windows, plus a reset in the middle of a window, are compared against a slot-by-slot model.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    localparam int unsigned DEF_NUM_CH        = 16;
    localparam int unsigned DEF_SAMPLES       = 8;
    localparam int unsigned DEF_HOLDOFF       = 5;
    localparam int unsigned DEF_WINDOW_CYCLES = 625;

    // width of a count that can reach n
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/coinc_chan_filter.sv
module coinc_chan_filter
    import coinc_pkg::*;
#(
    parameter int unsigned SAMPLES = DEF_SAMPLES,
    parameter int unsigned HOLDOFF = DEF_HOLDOFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SAMPLES-1:0] word_i,
    output logic [SAMPLES-1:0] accept_o
);
    localparam int unsigned HW = count_width(HOLDOFF);

    typedef struct packed {
        logic          last_smp;
        logic [HW-1:0] hold;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        logic          prev_smp;
        logic [HW-1:0] hold_left;
        st_d      = st_q;
        accept_o  = '0;
        prev_smp  = st_q.last_smp;
        hold_left = st_q.hold;
        // walk the samples from earliest to latest
        for (int k = 0; k < SAMPLES; k++) begin
            if (hold_left != '0) begin
                hold_left = hold_left - 1'b1;
            end else if (word_i[k] && !prev_smp) begin
                accept_o[k] = 1'b1;
                hold_left   = HW'(HOLDOFF);
            end
            prev_smp = word_i[k];
        end
        st_d.last_smp = word_i[SAMPLES-1];
        st_d.hold     = hold_left;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/coinc_merge.sv
module coinc_merge
    import coinc_pkg::*;
#(
    parameter int unsigned NUM_CH  = DEF_NUM_CH,
    parameter int unsigned SAMPLES = DEF_SAMPLES,
    localparam int unsigned CW     = count_width(SAMPLES)
) (
    input  logic [NUM_CH*SAMPLES-1:0] accept_i,
    output logic [SAMPLES-1:0]        slot_hit_o,
    output logic [CW-1:0]             evt_cnt_o
);
    // one OR tree per sample slot
    for (genvar k = 0; k < SAMPLES; k++) begin : g_slot
        logic [NUM_CH-1:0] column;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_col
            assign column[c] = accept_i[c*SAMPLES + k];
        end
        assign slot_hit_o[k] = |column;
    end

    always_comb begin
        evt_cnt_o = '0;
        for (int k = 0; k < SAMPLES; k++) begin
            evt_cnt_o = evt_cnt_o + CW'(slot_hit_o[k]);
        end
    end
endmodule

// File: rtl/coinc_window.sv
module coinc_window
    import coinc_pkg::*;
#(
    parameter int unsigned SAMPLES       = DEF_SAMPLES,
    parameter int unsigned WINDOW_CYCLES = DEF_WINDOW_CYCLES,
    localparam int unsigned CW           = count_width(SAMPLES),
    localparam int unsigned TW           = count_width(WINDOW_CYCLES * SAMPLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] evt_cnt_i,
    output logic [TW-1:0] total_o,
    output logic          valid_o
);
    localparam int unsigned WW = count_width(WINDOW_CYCLES - 1);
    localparam logic [WW-1:0] LAST_POS = WW'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [WW-1:0] pos;
        logic [TW-1:0] acc;
        logic [TW-1:0] total;
        logic          valid;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        logic [TW-1:0] sum;
        st_d       = st_q;
        st_d.valid = 1'b0;
        sum        = st_q.acc + TW'(evt_cnt_i);
        if (st_q.pos == LAST_POS) begin
            st_d.total = sum;
            st_d.valid = 1'b1;
            st_d.acc   = '0;
            st_d.pos   = '0;
        end else begin
            st_d.acc = sum;
            st_d.pos = st_q.pos + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign total_o = st_q.total;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/coinc_event_counter.sv
module coinc_event_counter
    import coinc_pkg::*;
#(
    parameter int unsigned NUM_CH        = DEF_NUM_CH,
    parameter int unsigned SAMPLES       = DEF_SAMPLES,
    parameter int unsigned HOLDOFF       = DEF_HOLDOFF,
    parameter int unsigned WINDOW_CYCLES = DEF_WINDOW_CYCLES,
    localparam int unsigned TW           = count_width(WINDOW_CYCLES * SAMPLES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CH*SAMPLES-1:0] trig_words,
    output logic [TW-1:0]             event_total,
    output logic                      count_valid
);
    localparam int unsigned CW = count_width(SAMPLES);

    logic [NUM_CH*SAMPLES-1:0] accept_all;
    logic [SAMPLES-1:0]        slot_hit;
    logic [CW-1:0]             evt_cnt;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        coinc_chan_filter #(
            .SAMPLES (SAMPLES),
            .HOLDOFF (HOLDOFF)
        ) u_filt (
            .clk      (clk),
            .rst      (rst),
            .word_i   (trig_words[c*SAMPLES +: SAMPLES]),
            .accept_o (accept_all[c*SAMPLES +: SAMPLES])
        );
    end

    coinc_merge #(
        .NUM_CH  (NUM_CH),
        .SAMPLES (SAMPLES)
    ) u_merge (
        .accept_i   (accept_all),
        .slot_hit_o (slot_hit),
        .evt_cnt_o  (evt_cnt)
    );

    coinc_window #(
        .SAMPLES       (SAMPLES),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .evt_cnt_i (evt_cnt),
        .total_o   (event_total),
        .valid_o   (count_valid)
    );
endmodule

// File: rtl/coinc_event_counter_chk.sv
module coinc_event_counter_chk
    import coinc_pkg::*;
#(
    parameter int unsigned NUM_CH        = DEF_NUM_CH,
    parameter int unsigned SAMPLES       = DEF_SAMPLES,
    parameter int unsigned WINDOW_CYCLES = DEF_WINDOW_CYCLES,
    localparam int unsigned TW           = count_width(WINDOW_CYCLES * SAMPLES),
    localparam int unsigned CW           = count_width(SAMPLES)
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_CH*SAMPLES-1:0] trig_words,
    input logic [CW-1:0]             evt_cnt,
    input logic [TW-1:0]             event_total,
    input logic                      count_valid
);
    localparam int unsigned WW = count_width(WINDOW_CYCLES - 1);

    logic [WW-1:0]      chk_pos;
    logic               chk_wrap;
    logic [SAMPLES-1:0] any_high;

    // independent window tracker
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_pos  <= '0;
            chk_wrap <= 1'b0;
        end else begin
            chk_wrap <= (chk_pos == WW'(WINDOW_CYCLES - 1));
            chk_pos  <= (chk_pos == WW'(WINDOW_CYCLES - 1)) ? '0 : chk_pos + 1'b1;
        end
    end

    always_comb begin
        any_high = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            any_high = any_high | trig_words[c*SAMPLES +: SAMPLES];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (event_total == '0 && !count_valid)); // R1

    AST_EVT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        int'(evt_cnt) <= $countones(any_high)); // R2

    AST_VALID_PERIOD: assert property (@(posedge clk) disable iff (rst)
        count_valid == chk_wrap); // R9

    AST_TOTAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !count_valid |-> $stable(event_total)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(event_total) <= WINDOW_CYCLES * SAMPLES); // R11
endmodule

bind coinc_event_counter coinc_event_counter_chk #(
    .NUM_CH        (NUM_CH),
    .SAMPLES       (SAMPLES),
    .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig_words  (trig_words),
    .evt_cnt     (evt_cnt),
    .event_total (event_total),
    .count_valid (count_valid)
);

// File: tb/coinc_event_counter_bench.sv
module coinc_event_counter_bench;
    localparam int NCH  = 16;
    localparam int NS   = 8;
    localparam int HOLD = 5;
    localparam int WIN  = 625;
    localparam int W    = NCH * NS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] trig = '0;
    logic [12:0]  event_total;
    logic         count_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state
    logic   m_prev [NCH];
    int     m_hold [NCH];
    int     m_acc, m_pos, m_total;
    logic   m_valid;

    logic [W-1:0] stim_q[$];

    coinc_event_counter u_coinc_event_counter (
        .clk         (clk),
        .rst         (rst),
        .trig_words  (trig),
        .event_total (event_total),
        .count_valid (count_valid)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [W-1:0] put(input int ch, input logic [NS-1:0] v);
        logic [W-1:0] r = '0;
        r[ch*NS +: NS] = v;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_prev[c] = 1'b0;
            m_hold[c] = 0;
        end
        m_acc = 0; m_pos = 0; m_total = 0; m_valid = 1'b0;
    endfunction

    // events of one word set, slot by slot from the requirements
    function automatic int model_events(input logic [W-1:0] w);
        logic [NS-1:0] hit = '0;
        int n = 0;
        for (int c = 0; c < NCH; c++) begin
            logic p = m_prev[c];
            for (int k = 0; k < NS; k++) begin
                logic s = w[c*NS + k];
                if (m_hold[c] > 0) m_hold[c]--;
                else if (s && !p) begin
                    hit[k] = 1'b1;
                    m_hold[c] = HOLD;
                end
                p = s;
            end
            m_prev[c] = w[c*NS + NS - 1];
        end
        for (int k = 0; k < NS; k++) n += hit[k];
        return n;
    endfunction

    task automatic step(input logic [W-1:0] w);
        int ev;
        @(negedge clk);
        rst  = 1'b0;
        trig = w;
        ev = model_events(w);
        @(posedge clk);
        #1;
        if (m_pos == WIN - 1) begin
            m_total = m_acc + ev;
            m_valid = 1'b1;
            m_acc   = 0;
            m_pos   = 0;
        end else begin
            m_acc  += ev;
            m_pos++;
            m_valid = 1'b0;
        end
        if (count_valid !== m_valid) begin
            tests++;
            fails++;
            $display("FAIL R9: count_valid actual %0b expected %0b", count_valid, m_valid);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        trig = '0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        check("R1 total after reset", int'(event_total), 0);
        check("R1 valid after reset", int'(count_valid), 0);
    endtask

    // one full window; queued words first, zeros after
    task automatic run_window(input string req, input int exp, input bit use_exp);
        for (int i = 0; i < WIN; i++) begin
            if (stim_q.size() > 0) step(stim_q.pop_front());
            else step('0);
        end
        check("R9 pulse at window end", int'(count_valid), 1);
        check("R10 total vs model", int'(event_total), m_total);
        if (use_exp) check(req, int'(event_total), exp);
    endtask

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();

        // R2: isolated pulse plus a level held high for three words
        stim_q.push_back(put(0, 8'h3C));
        stim_q.push_back('0);
        stim_q.push_back(put(1, 8'hFF));
        stim_q.push_back(put(1, 8'hFF));
        stim_q.push_back(put(1, 8'hFF));
        run_window("R2 edges only", 2, 1);

        // R3: high across boundary gives nothing; 0 then 1 at boundary counts
        stim_q.push_back(put(0, 8'h80));
        stim_q.push_back(put(0, 8'hFF));
        stim_q.push_back(put(2, 8'h00));
        stim_q.push_back(put(2, 8'h01));
        run_window("R3 word boundary", 2, 1);

        // R4: t+1..t+5 blocked, t+6 and t+7 accepted
        stim_q.push_back(put(3, 8'hA9));
        stim_q.push_back('0);
        stim_q.push_back(put(3, 8'h41));
        run_window("R4 hold-off length", 4, 1);

        // R5: hold-off from slot 6 reaches into the next word
        stim_q.push_back(put(4, 8'h40));
        stim_q.push_back(put(4, 8'h52));
        run_window("R5 hold-off across words", 2, 1);

        // R6: all lines in one slot, then three lines in one slot
        stim_q.push_back({NCH{8'h01}});
        stim_q.push_back('0);
        stim_q.push_back(put(5, 8'h10) | put(9, 8'h10) | put(15, 8'h10));
        run_window("R6 coincidence merge", 2, 1);

        // R7: distinct slots on distinct lines
        stim_q.push_back(put(0, 8'h01) | put(1, 8'h02) | put(2, 8'h04));
        run_window("R7 separate slots", 3, 1);

        // R8: line 6 blocked at slot 3 while line 7 fires there
        stim_q.push_back(put(6, 8'h09) | put(7, 8'h08));
        run_window("R8 per-line hold-off", 2, 1);

        // R11: eight events every cycle
        for (int i = 0; i < WIN; i++) begin
            logic [W-1:0] w = '0;
            for (int c = 0; c < NS; c++) w |= put(c, 8'(1 << c));
            stim_q.push_back(w);
        end
        run_window("R11 full-scale total", 5000, 1);
        stim_q.push_back('0);
        run_window("R10 total after saturation", 0, 1);

        // R10: sparse random windows against the model
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < WIN; i++) begin
                logic [W-1:0] w;
                for (int j = 0; j < W / 32; j++)
                    w[j*32 +: 32] = $urandom & $urandom & $urandom;
                stim_q.push_back(w);
            end
            run_window("R10 random window", 0, 0);
        end

        // R1: reset in the middle of a window, then a clean window
        for (int i = 0; i < 300; i++) step(put(i % NCH, 8'h24));
        do_reset();
        stim_q.push_back(put(8, 8'h01));
        run_window("R1 restart after mid-window reset", 1, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule